// File: doc/BRIEF.md
# Bit-Sliced Multi-Function ALU

This block is a combinational arithmetic/logic unit of configurable width. It is assembled from identical one-bit cells that are chained by a ripple carry. Every cell receives one bit of each operand, the carry from the cell below it, and the shared operation controls. It returns one result bit and a carry for the cell above it.

A two-bit selector picks the result family: arithmetic, inverted second operand, OR, or AND. A separate invert bit turns the arithmetic family from addition into subtraction. It does this by complementing the second operand inside every cell and by feeding a carry of 1 into the lowest cell. The invert bit has no effect on the three logic families.

Two flags come with the result word. The first is a signed overflow flag, taken from the carries around the top cell. It is forced low for the logic families. The second flag reports whether any result bit is set. The unit is meant to sit in the execute step of a simple processor datapath, driven directly by decoded control bits.

Top module: `bitslice_alu`

## Requirements
- R1: With sel=0 and sub_inv=0, result equals (op_a + op_b) modulo 2^WIDTH.
- R2: With sel=0 and sub_inv=1, result equals (op_a - op_b) modulo 2^WIDTH.
- R3: With sel=1, result equals the bitwise complement of op_b, and sub_inv has no effect on result.
- R4: With sel=2, result equals op_a OR op_b, and with sel=3, result equals op_a AND op_b; in both cases sub_inv has no effect on result.
- R5: For addition, ovf is 1 exactly when op_a and op_b have the same sign bit and the result's sign bit differs from it, the operands being read as two's complement.
- R6: For subtraction, ovf is 1 exactly when op_a and op_b have different sign bits and the result's sign bit differs from that of op_a.
- R7: For sel values 1, 2 and 3, ovf is 0.
- R8: For every operation, nonzero is 1 exactly when at least one bit of result is 1.
- R9: A carry produced in cell i reaches cell i+1, so adding 1 to an all-ones op_a yields a zero result with nonzero=0 and ovf=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sel | input | 2 | Result family: 0 arithmetic, 1 NOT op_b, 2 OR, 3 AND |
| sub_inv | input | 1 | Arithmetic family only: 0 add, 1 subtract |
| result | output | WIDTH | Result word |
| ovf | output | 1 | Signed overflow of add or subtract, 0 otherwise |
| nonzero | output | 1 | 1 when result has any bit set |

## Verification
A 4-bit copy of the unit is swept over every operand pair, every selector value and both invert values. This exposes the sign boundary at the most negative value, subtraction of equal operands, and results that wrap to zero.

A design that took overflow from the final carry alone would flag an unsigned wrap, such as -1 + 1, as signed overflow. A design that got the subtract carry-in wrong would be off by one on every difference. A design that let the invert bit leak into the logic families would return corrupted NOT, OR or AND words.

A 32-bit copy is driven with the same extremes, including the full-width carry ripple of all-ones plus one, so that a broken link high in the chain or a faulty nonzero reduction shows up at the default width.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;
   typedef enum logic [1:0] {
      SEL_ARITH = 2'd0,
      SEL_NOTB  = 2'd1,
      SEL_OR    = 2'd2,
      SEL_AND   = 2'd3
   } sel_t;
endpackage

// File: rtl/bitslice_alu_cell.sv
module bitslice_alu_cell
   import bitslice_alu_pkg::*;
(
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic       c_in,
   input  logic       inv,
   input  logic [1:0] sel,
   output logic       r_bit,
   output logic       c_out
);
   logic b_eff;
   logic half;
   logic sum_bit;

   // Second operand is complemented for subtraction only.
   assign b_eff   = b_bit ^ inv;
   assign half    = a_bit ^ b_eff;
   assign sum_bit = half ^ c_in;
   assign c_out   = (a_bit & b_eff) | (c_in & half);

   always_comb begin
      unique case (sel_t'(sel))
         SEL_ARITH: r_bit = sum_bit;
         SEL_NOTB:  r_bit = ~b_bit;
         SEL_OR:    r_bit = a_bit | b_bit;
         default:   r_bit = a_bit & b_bit;
      endcase
   end
endmodule

// File: rtl/bitslice_alu_flags.sv
module bitslice_alu_flags #(
   parameter int WIDTH   = 32,
   parameter bit NZ_TREE = 1'b1
) (
   input  logic [WIDTH-1:0] res,
   input  logic             carry_into_top,
   input  logic             carry_out_top,
   input  logic             arith,
   output logic             ovf,
   output logic             nz
);
   assign ovf = arith & (carry_into_top ^ carry_out_top);

   generate
      if (NZ_TREE) begin : g_nz_tree
         assign nz = |res;
      end else begin : g_nz_chain
         logic [WIDTH-1:0] any_set;
         assign any_set[0] = res[0];
         for (genvar k = 1; k < WIDTH; k++) begin : g_link
            assign any_set[k] = any_set[k-1] | res[k];
         end
         assign nz = any_set[WIDTH-1];
      end
   endgenerate
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import bitslice_alu_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter bit NZ_TREE = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       sel,
   input  logic             sub_inv,
   output logic [WIDTH-1:0] result,
   output logic             ovf,
   output logic             nonzero
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitslice_alu: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH:0] carry;
   logic           arith;

   assign carry[0] = sub_inv;
   assign arith    = (sel_t'(sel) == SEL_ARITH);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         bitslice_alu_cell u_cell (
            .a_bit (op_a[i]),
            .b_bit (op_b[i]),
            .c_in  (carry[i]),
            .inv   (sub_inv),
            .sel   (sel),
            .r_bit (result[i]),
            .c_out (carry[i+1])
         );
      end
   endgenerate

   bitslice_alu_flags #(
      .WIDTH   (WIDTH),
      .NZ_TREE (NZ_TREE)
   ) u_flags (
      .res            (result),
      .carry_into_top (carry[MSB]),
      .carry_out_top  (carry[WIDTH]),
      .arith          (arith),
      .ovf            (ovf),
      .nz             (nonzero)
   );

   always_comb begin
      if (arith && !sub_inv) begin
         assert_add_R1: assert (result == op_a + op_b);
         assert_add_ovf_R5: assert (ovf == ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])));
      end
      if (arith && sub_inv) begin
         assert_sub_R2: assert (result == op_a - op_b);
         assert_sub_ovf_R6: assert (ovf == ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])));
      end
      if (sel_t'(sel) == SEL_NOTB) begin
         assert_notb_R3: assert (result == ~op_b);
      end
      if (sel_t'(sel) == SEL_OR) begin
         assert_or_R4: assert (result == (op_a | op_b));
      end
      if (sel_t'(sel) == SEL_AND) begin
         assert_and_R4: assert (result == (op_a & op_b));
      end
      if (!arith) begin
         assert_no_overflow_R7: assert (!ovf);
      end
      assert_nonzero_R8: assert (nonzero == (result != '0));
   end
endmodule

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;
   localparam int NW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [NW-1:0] na, nb, nres;
   logic [WW-1:0] wa, wb, wres;
   logic [1:0]    nsel, wsel;
   logic          nf, wf, novf, wovf, nnz, wnz;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   bitslice_alu #(.WIDTH(NW), .NZ_TREE(1'b0)) uut (
      .op_a(na), .op_b(nb), .sel(nsel), .sub_inv(nf),
      .result(nres), .ovf(novf), .nonzero(nnz)
   );

   bitslice_alu #(.WIDTH(WW)) wide_uut (
      .op_a(wa), .op_b(wb), .sel(wsel), .sub_inv(wf),
      .result(wres), .ovf(wovf), .nonzero(wnz)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Expected values from plain integer arithmetic.
   task automatic model(input int w, input longint a, input longint b,
                        input int s, input int f,
                        output longint r, output longint ov, output longint nz);
      longint m, sa, sb, sr, full;
      m  = (longint'(1) << w) - 1;
      sa = a[w-1] ? a - (longint'(1) << w) : a;
      sb = b[w-1] ? b - (longint'(1) << w) : b;
      ov = 0;
      case (s)
         0: begin
            full = f ? (sa - sb) : (sa + sb);
            r    = full & m;
            sr   = (longint'(1) << (w-1));
            ov   = (full >= sr || full < -sr) ? 1 : 0;
         end
         1: r = (~b) & m;
         2: r = (a | b) & m;
         default: r = (a & b) & m;
      endcase
      nz = (r != 0) ? 1 : 0;
   endtask

   function automatic string rtag(input int s, input int f);
      if (s == 0) return f ? "R2" : "R1";
      if (s == 1) return "R3";
      return "R4";
   endfunction

   function automatic string otag(input int s, input int f);
      if (s == 0) return f ? "R6" : "R5";
      return "R7";
   endfunction

   task automatic narrow(input int a, input int b, input int s, input int f);
      longint r, ov, nz;
      @(posedge clk);
      na = NW'(a); nb = NW'(b); nsel = 2'(s); nf = f[0];
      @(negedge clk);
      model(NW, longint'(a), longint'(b), s, f, r, ov, nz);
      chk({rtag(s, f), " narrow result"}, longint'(nres), r);
      chk({otag(s, f), " narrow ovf"}, longint'(novf), ov);
      chk("R8 narrow nonzero", longint'(nnz), nz);
   endtask

   task automatic wide(input longint a, input longint b, input int s, input int f);
      longint r, ov, nz;
      @(posedge clk);
      wa = WW'(a); wb = WW'(b); wsel = 2'(s); wf = f[0];
      @(negedge clk);
      model(WW, a & 64'hFFFF_FFFF, b & 64'hFFFF_FFFF, s, f, r, ov, nz);
      chk({rtag(s, f), " wide result"}, longint'(wres), r);
      chk({otag(s, f), " wide ovf"}, longint'(wovf), ov);
      chk("R8 wide nonzero", longint'(wnz), nz);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         misses++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      na = '0; nb = '0; nsel = '0; nf = 1'b0;
      wa = '0; wb = '0; wsel = '0; wf = 1'b0;
      @(negedge clk);
      // Idle state: zero operands added.
      chk("R1 idle result", longint'(wres), 0);
      chk("R8 idle nonzero", longint'(wnz), 0);
      chk("R5 idle ovf", longint'(wovf), 0);

      // Exhaustive narrow sweep covers R1..R8.
      for (int s = 0; s < 4; s++)
         for (int f = 0; f < 2; f++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++)
                  narrow(a, b, s, f);

      // Wide corner cases at every operation.
      for (int s = 0; s < 4; s++)
         for (int f = 0; f < 2; f++) begin
            wide(64'h8000_0000, 64'h8000_0000, s, f);
            wide(64'h8000_0000, 64'h0000_0001, s, f);
            wide(64'h7FFF_FFFF, 64'h0000_0001, s, f);
            wide(64'hFFFF_FFFF, 64'hFFFF_FFFF, s, f);
            wide(64'h1234_5678, 64'h1234_5678, s, f);
            wide(64'h0000_0000, 64'h8000_0000, s, f);
            wide(64'hA5A5_0F0F, 64'h5A5A_F0F0, s, f);
            wide(64'h0000_0000, 64'h0000_0000, s, f);
         end

      // R9: carry ripples the full chain.
      wide(64'hFFFF_FFFF, 64'h0000_0001, 0, 0);
      chk("R9 ripple result", longint'(wres), 0);
      chk("R9 ripple nonzero", longint'(wnz), 0);
      chk("R9 ripple ovf", longint'(wovf), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule